// File: doc/BRIEF.md
# SPI Flash Command Framing Validator

This block is the serial front end of a SPI NOR flash slave. It oversamples chip select, serial clock and serial data with the system clock. It collects the bits most significant first into an opcode byte, up to three address bytes and any data bytes that follow. When chip select returns high, it decides whether a write-type command is committed or quietly dropped.

A committed command appears as a one-cycle execute pulse that carries the opcode, the 24-bit address and the data byte count. Page program data bytes are handed out one at a time on a strobe while the frame is still in progress. The write-enable latch is kept inside the block. Read commands only raise an activity flag, because a read may be cut off at any bit. The array, the output shifter and program/erase timing live elsewhere, and `busy_i` stands in for them.

Top module: `spi_cmd_frame`

## Requirements
- R1: Bits are taken on rising serial clock edges while chip select is low, most significant bit first. Byte 0 is the opcode. Bytes 1, 2 and 3 land in `exec_addr_o[23:16]`, `[15:8]` and `[7:0]`.
- R2: Opcode 06h sets `wel_o` and opcode 04h clears it.
- R3: Any write-type command is dropped when chip select rises with a clock edge count that is not a multiple of eight. In that case `wel_o` keeps its value.
- R4: Page program (02h) commits only when at least 4 whole bytes follow the opcode. `exec_cnt_o` then equals the number of data bytes. A short or partial frame has no effect and leaves `wel_o` set.
- R5: Sector erase (20h) and block erase (D8h) commit only when exactly 3 bytes follow the opcode.
- R6: Chip erase (C7h or 60h) and deep power-down (B9h) are single-byte commands. Deep power-down commits without the write-enable latch.
- R7: Page program, erase and write-status are dropped when `wel_o` is clear. A committed one clears `wel_o`.
- R8: Write-status (01h) commits only with exactly one status byte, which appears in `exec_addr_o[23:16]`.
- R9: While `busy_i` is high at the chip select rise, every write-type command is ignored, and no page program strobes are issued for that data.
- R10: `pp_strobe_o` pulses once per completed data byte (byte index 4 or later) of an enabled page program, and `pp_data_o` holds that byte.
- R11: Read opcodes 03h and 05h raise `rd_active_o` once the opcode is complete and hold it until chip select rises. They may end at any bit, they never produce an execute pulse and they leave `wel_o` unchanged.
- R12: After reset `wel_o`, `exec_o` and `rd_active_o` are 0. `exec_o` is a single-cycle pulse per committed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| busy_i | input | 1 | Internal write/program/erase cycle running |
| exec_o | output | 1 | One-cycle commit pulse |
| exec_op_o | output | 8 | Committed opcode |
| exec_addr_o | output | 24 | Committed address bytes |
| exec_cnt_o | output | CNT_W | Page program data byte count |
| pp_strobe_o | output | 1 | Page program data byte valid |
| pp_data_o | output | 8 | Page program data byte |
| wel_o | output | 1 | Write-enable latch |
| rd_active_o | output | 1 | Read command data-out phase in progress |

## Verification
Two things can coincide in one cycle: the commit decision at the chip select rise and `busy_i` being sampled. When both happen together, busy has to win. The bench holds `busy_i` high across the whole deassertion window, while `wel_o` is set and the command is otherwise well formed. It then checks three things: no execute pulse occurs, no data strobe is issued, and the latch is untouched, even by a write-disable. A second run with `busy_i` low and the same frames must commit, which shows that the earlier silence came from busy and not from the framing.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE_A = 8'hC7;
  localparam logic [7:0] OP_CE_B = 8'h60;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_RDSR = 8'h05;

  function automatic logic needs_wel(input logic [7:0] op);
    return (op == OP_PP) || (op == OP_SE) || (op == OP_BE) ||
           (op == OP_CE_A) || (op == OP_CE_B) || (op == OP_WRSR);
  endfunction

  function automatic logic is_read(input logic [7:0] op);
    return (op == OP_READ) || (op == OP_RDSR);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_n_o,
  output logic sdi_o,
  output logic sck_rise_o,
  output logic cs_rise_o
);
  // lane order: {cs_n, sck, sdi}
  logic [2:0] stg_q [STAGES];
  logic       sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= 3'b100;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      stg_q[0] <= {cs_n_i, sck_i, sdi_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sck_q <= stg_q[STAGES-1][1];
      cs_q  <= stg_q[STAGES-1][2];
    end
  end

  assign cs_n_o     = stg_q[STAGES-1][2];
  assign sdi_o      = stg_q[STAGES-1][0];
  assign sck_rise_o = stg_q[STAGES-1][1] & ~sck_q & ~stg_q[STAGES-1][2];
  assign cs_rise_o  = stg_q[STAGES-1][2] & ~cs_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sdi_i,
  input  logic             sck_rise_i,
  output logic [2:0]       bit_cnt_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_idx_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [6:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      bit_cnt_o  <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
    end else if (cs_n_i) begin
      shreg_q    <= '0;
      bit_cnt_o  <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (sck_rise_i) begin
        shreg_q   <= {shreg_q[5:0], sdi_i};
        bit_cnt_o <= bit_cnt_o + 3'd1;
        if (bit_cnt_o == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {shreg_q, sdi_i};
          byte_idx_o <= byte_cnt_o;
          if (byte_cnt_o != CNT_MAX) byte_cnt_o <= byte_cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_decide.sv
module spi_cmd_decide
  import spi_cmd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_rise_i,
  input  logic             busy_i,
  input  logic [2:0]       bit_cnt_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] byte_idx_i,
  output logic             exec_o,
  output logic [7:0]       exec_op_o,
  output logic [23:0]      exec_addr_o,
  output logic [CNT_W-1:0] exec_cnt_o,
  output logic             pp_strobe_o,
  output logic [7:0]       pp_data_o,
  output logic             wel_o,
  output logic             rd_active_o
);
  logic [7:0]       op_q;
  logic [23:0]      addr_q;
  logic             acc, set_wel, clr_wel;
  logic [CNT_W-1:0] cnt;
  logic             framed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q        <= '0;
      addr_q      <= '0;
      rd_active_o <= 1'b0;
      pp_strobe_o <= 1'b0;
      pp_data_o   <= '0;
    end else begin
      pp_strobe_o <= 1'b0;
      if (cs_rise_i) rd_active_o <= 1'b0;
      if (byte_vld_i) begin
        if (byte_idx_i == '0) begin
          op_q        <= byte_i;
          addr_q      <= '0;
          rd_active_o <= is_read(byte_i);
        end else if (byte_idx_i == CNT_W'(1)) addr_q[23:16] <= byte_i;
        else if (byte_idx_i == CNT_W'(2))     addr_q[15:8]  <= byte_i;
        else if (byte_idx_i == CNT_W'(3))     addr_q[7:0]   <= byte_i;
        else if (op_q == OP_PP && wel_o && !busy_i) begin
          pp_strobe_o <= 1'b1;
          pp_data_o   <= byte_i;
        end
      end
    end
  end

  // commit-or-reject at chip select rise
  assign framed = cs_rise_i && (bit_cnt_i == 3'd0) && (byte_cnt_i != '0) && !busy_i;

  always_comb begin
    acc     = 1'b0;
    set_wel = 1'b0;
    clr_wel = 1'b0;
    cnt     = '0;
    if (framed) begin
      unique case (op_q)
        OP_WREN:          set_wel = 1'b1;
        OP_WRDI:          clr_wel = 1'b1;
        OP_DP:            acc = 1'b1;
        OP_CE_A, OP_CE_B: acc = wel_o;
        OP_SE, OP_BE:     acc = wel_o && (byte_cnt_i == CNT_W'(4));
        OP_WRSR:          acc = wel_o && (byte_cnt_i == CNT_W'(2));
        OP_PP: begin
          acc = wel_o && (byte_cnt_i >= CNT_W'(5));
          cnt = byte_cnt_i - CNT_W'(4);
        end
        default: ;
      endcase
      if (acc && needs_wel(op_q)) clr_wel = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_o      <= 1'b0;
      exec_op_o   <= '0;
      exec_addr_o <= '0;
      exec_cnt_o  <= '0;
      wel_o       <= 1'b0;
    end else begin
      exec_o <= acc;
      if (acc) begin
        exec_op_o   <= op_q;
        exec_addr_o <= addr_q;
        exec_cnt_o  <= cnt;
      end
      if (set_wel)      wel_o <= 1'b1;
      else if (clr_wel) wel_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame #(
  parameter int CNT_W     = 10,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             busy_i,
  output logic             exec_o,
  output logic [7:0]       exec_op_o,
  output logic [23:0]      exec_addr_o,
  output logic [CNT_W-1:0] exec_cnt_o,
  output logic             pp_strobe_o,
  output logic [7:0]       pp_data_o,
  output logic             wel_o,
  output logic             rd_active_o
);
  logic             cs_n_s, sdi_s, sck_rise, cs_rise;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt, byte_idx;
  logic             byte_vld;
  logic [7:0]       byte_val;

  spi_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i, .rst_ni, .cs_n_i, .sck_i, .sdi_i,
    .cs_n_o(cs_n_s), .sdi_o(sdi_s), .sck_rise_o(sck_rise), .cs_rise_o(cs_rise)
  );

  spi_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni, .cs_n_i(cs_n_s), .sdi_i(sdi_s), .sck_rise_i(sck_rise),
    .bit_cnt_o(bit_cnt), .byte_cnt_o(byte_cnt), .byte_vld_o(byte_vld),
    .byte_o(byte_val), .byte_idx_o(byte_idx)
  );

  spi_cmd_decide #(.CNT_W(CNT_W)) u_dec (
    .clk_i, .rst_ni, .cs_rise_i(cs_rise), .busy_i,
    .bit_cnt_i(bit_cnt), .byte_cnt_i(byte_cnt), .byte_vld_i(byte_vld),
    .byte_i(byte_val), .byte_idx_i(byte_idx),
    .exec_o, .exec_op_o, .exec_addr_o, .exec_cnt_o,
    .pp_strobe_o, .pp_data_o, .wel_o, .rd_active_o
  );
endmodule

// File: rtl/spi_cmd_frame_chk.sv
module spi_cmd_frame_chk
  import spi_cmd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             exec_o,
  input logic [7:0]       exec_op_o,
  input logic [CNT_W-1:0] exec_cnt_o,
  input logic             pp_strobe_o,
  input logic             wel_o,
  input logic             rd_active_o
);
  p_exec_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);

  p_wel_consumed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && needs_wel(exec_op_o)) |-> (!wel_o && $past(wel_o)));

  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> !$past(busy_i));

  p_pp_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && exec_op_o == OP_PP) |-> (exec_cnt_o != '0));

  p_strobe_not_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pp_strobe_o |-> !rd_active_o);

  p_read_no_exec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> !is_read(exec_op_o));
endmodule

bind spi_cmd_frame spi_cmd_frame_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .exec_o(exec_o),
  .exec_op_o(exec_op_o), .exec_cnt_o(exec_cnt_o), .pp_strobe_o(pp_strobe_o),
  .wel_o(wel_o), .rd_active_o(rd_active_o)
);

// File: tb/spi_cmd_frame_tb.sv
module spi_cmd_frame_tb_top;
  localparam int CNT_W = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic             exec, pp_strobe, wel, rd_active;
  logic [7:0]       exec_op, pp_data;
  logic [23:0]      exec_addr;
  logic [CNT_W-1:0] exec_cnt;

  int n_chk = 0, n_bad = 0;
  int exec_seen = 0, strobe_seen = 0;
  logic rd_seen = 1'b0;
  logic [7:0]       last_op = '0, last_pp = '0;
  logic [23:0]      last_addr = '0;
  logic [CNT_W-1:0] last_cnt = '0;

  always #5 clk = ~clk;

  spi_cmd_frame #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .busy_i(busy), .exec_o(exec), .exec_op_o(exec_op), .exec_addr_o(exec_addr),
    .exec_cnt_o(exec_cnt), .pp_strobe_o(pp_strobe), .pp_data_o(pp_data),
    .wel_o(wel), .rd_active_o(rd_active)
  );

  always @(negedge clk) begin
    if (exec) begin
      exec_seen++;
      last_op   = exec_op;
      last_addr = exec_addr;
      last_cnt  = exec_cnt;
    end
    if (pp_strobe) begin
      strobe_seen++;
      last_pp = pp_data;
    end
    if (rd_active) rd_seen = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [127:0] data, input int nbits);
    exec_seen = 0;
    strobe_seen = 0;
    cs_n = 1'b0;
    #40;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = data[i];
      #40 sck = 1'b1;
      #40 sck = 1'b0;
    end
    #40 cs_n = 1'b1;
    #200;
  endtask

  task automatic t_reset;
    chk("R12 wel after reset", wel, 0);
    chk("R12 exec after reset", exec, 0);
    chk("R12 rd_active after reset", rd_active, 0);
  endtask

  task automatic t_wel_cmds;
    frame(8'h06, 8);
    chk("R2 wren sets wel", wel, 1);
    frame(8'h04, 8);
    chk("R2 wrdi clears wel", wel, 0);
  endtask

  task automatic t_misalign;
    frame({8'h06, 1'b1}, 9);
    chk("R3 misaligned wren ignored", wel, 0);
  endtask

  task automatic t_pp;
    frame(8'h06, 8);
    frame({8'h02, 24'h123456, 8'hA5, 8'h3C}, 48);
    chk("R4 pp commits once", exec_seen, 1);
    chk("R1 opcode", last_op, 8'h02);
    chk("R1 address msb first", last_addr, 24'h123456);
    chk("R4 data count", last_cnt, 2);
    chk("R10 strobe count", strobe_seen, 2);
    chk("R10 last strobe data", last_pp, 8'h3C);
    chk("R7 accepted pp clears wel", wel, 0);
    frame(8'h06, 8);
    frame({8'h02, 24'h000100}, 32);
    chk("R4 pp without data rejected", exec_seen, 0);
    chk("R4 wel kept after short pp", wel, 1);
    frame({8'h02, 24'h000100, 8'h11, 3'b101}, 43);
    chk("R3 partial pp rejected", exec_seen, 0);
    chk("R4 wel kept after partial pp", wel, 1);
  endtask

  task automatic t_erase;
    frame({8'h20, 24'h045000, 8'h00}, 40);
    chk("R5 sector erase with extra byte rejected", exec_seen, 0);
    frame({8'hD8, 16'h0700}, 24);
    chk("R5 block erase with short address rejected", exec_seen, 0);
    frame({8'h20, 24'h045000}, 32);
    chk("R5 sector erase commits", exec_seen, 1);
    chk("R5 sector erase address", last_addr, 24'h045000);
    chk("R7 erase clears wel", wel, 0);
    frame({8'hD8, 24'h070000}, 32);
    chk("R7 block erase without wel rejected", exec_seen, 0);
  endtask

  task automatic t_chip_dp;
    frame(8'hC7, 8);
    chk("R7 chip erase without wel rejected", exec_seen, 0);
    frame(8'h06, 8);
    frame(8'h60, 8);
    chk("R6 chip erase 60h commits", exec_seen, 1);
    chk("R6 chip erase opcode", last_op, 8'h60);
    frame(8'hB9, 8);
    chk("R6 deep power-down needs no wel", exec_seen, 1);
    chk("R6 deep power-down opcode", last_op, 8'hB9);
  endtask

  task automatic t_wrsr;
    frame(8'h06, 8);
    frame({8'h01, 8'h55, 8'h66}, 24);
    chk("R8 two status bytes rejected", exec_seen, 0);
    chk("R8 wel kept", wel, 1);
    frame({8'h01, 8'h55}, 16);
    chk("R8 write status commits", exec_seen, 1);
    chk("R8 status byte position", last_addr[23:16], 8'h55);
  endtask

  task automatic t_busy;
    frame(8'h06, 8);
    busy = 1'b1;
    frame(8'h04, 8);
    chk("R9 wrdi ignored while busy", wel, 1);
    frame({8'h02, 24'h000200, 8'h77}, 40);
    chk("R9 pp ignored while busy", exec_seen, 0);
    chk("R9 no strobes while busy", strobe_seen, 0);
    chk("R9 wel untouched while busy", wel, 1);
    busy = 1'b0;
    frame({8'h02, 24'h000200, 8'h77}, 40);
    chk("R9 pp commits after busy", exec_seen, 1);
    chk("R10 strobe after busy", strobe_seen, 1);
  endtask

  task automatic t_read;
    frame(8'h06, 8);
    rd_seen = 1'b0;
    frame({8'h03, 24'h001000, 5'b10110}, 37);
    chk("R11 rd_active raised", rd_seen, 1);
    chk("R11 read no exec", exec_seen, 0);
    chk("R11 read keeps wel", wel, 1);
    chk("R11 rd_active cleared after cs", rd_active, 0);
    rd_seen = 1'b0;
    frame({8'h05, 3'b011}, 11);
    chk("R11 status read raises flag", rd_seen, 1);
    chk("R11 status read no exec", exec_seen, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b1;
    #20;
    t_reset();
    t_wel_cmds();
    t_misalign();
    t_pp();
    t_erase();
    t_chip_dp();
    t_wrsr();
    t_busy();
    t_read();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule